// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative buffer of virtual-to-physical page translations. Each entry carries a three-bit address-space tag, so translations that belong to several processes can sit in the buffer together. A change of context does not empty the buffer. Software loads the base address of the new translation table, called the origin, and the block searches a short stack of recently used origins. A match makes that slot's number the current tag, and the buffer contents stay as they are. A mismatch hands one slot to the new origin and clears only the entries that carried that slot's tag.

Lookups are combinational against the current tag. A miss is resolved by an external table walker, which writes the translation back through the fill port. Software can also clear the whole buffer, or every translation of a single virtual page whatever its tag. A build option replaces the stack with the simple scheme, in which every origin load empties the whole buffer.

Top module: `tagged_xlat_buf`

## Requirements
- R1: After reset no entry is valid, no stack slot is in use, `cur_tag` reads 7 (the no-space code) and `lk_hit` is 0.
- R2: `lk_hit` is 1 in the same cycle, and `lk_pfn` gives the stored frame, only when a valid entry holds `lk_vpn` and carries a tag equal to `cur_tag`. An entry stored under another tag does not hit.
- R3: An origin load whose value is already held by a stack slot makes that slot's index (0 to 6) the current tag from the next cycle and leaves every buffer entry untouched. With no origin load, `cur_tag` holds its value.
- R4: An origin load that matches no slot takes the lowest-numbered unused slot. When all 7 slots are in use it takes a round-robin slot: first slot 0, then 1, and so on, wrapping after 6. From the next cycle every entry tagged with that slot is invalid and `cur_tag` is the slot index. Entries under the other tags survive.
- R5: `purge_all` invalidates every entry whatever its tag, and leaves the origin stack unchanged.
- R6: `inval_en` invalidates every entry whose page equals `inval_vpn`, under any tag.
- R7: A fill writes page, frame and the current tag into the lowest-numbered invalid entry. When no entry is invalid it overwrites a round-robin victim, starting at entry 0 and advancing by one with each such overwrite.
- R8: In one cycle the origin load and the purges act first and the fill follows. A fill that arrives with an origin load therefore carries the new tag, and a purge in the same cycle does not remove it.
- R9: A fill that arrives while no origin has been loaded (tag code 7) is dropped.
- R10: With `SEL_PURGE` set to 0, every origin load empties the whole buffer and sets `cur_tag` to 0, even when the same origin is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| org_load | input | 1 | Load a new translation-table origin |
| org_val | input | ORG_W | Origin value being loaded |
| lk_vpn | input | VPN_W | Virtual page to look up |
| lk_hit | output | 1 | Lookup hit under the current tag |
| lk_pfn | output | PFN_W | Frame number of the hit entry |
| fill_en | input | 1 | Write a translation from the walker |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| purge_all | input | 1 | Invalidate every entry |
| inval_en | input | 1 | Invalidate one virtual page under all tags |
| inval_vpn | input | VPN_W | Page to invalidate |
| cur_tag | output | 3 | Tag of the current address space (7 means none) |

## Verification
The origin stack is driven through directed patterns. Reloading a held origin separates reuse of a slot from a purge. Loading eight distinct origins shows whether eviction is round-robin and whether the purge touches only the tag of the evicted slot. Filling the buffer past 16 entries separates placement in the first free entry from round-robin overwrite. Loads that coincide with fills, and invalidates spread across two tags, expose errors in ordering and tag matching. A long random mix over ten origins and twelve pages compares every lookup with a model in the bench. A second instance built in the flush-on-load variant is checked to lose its entries when the same origin is loaded again.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int unsigned TAG_W = 3;
   typedef logic [TAG_W-1:0] tag_t;
   localparam tag_t TAG_NONE = '1;
endpackage

// File: rtl/xlat_first_free.sv
module xlat_first_free #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  busy,
   output logic          found,
   output logic [IW-1:0] idx
);
   // Lowest clear bit wins: the scan runs downward so the last write is the lowest index.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/xlat_origin_stack.sv
module xlat_origin_stack
   import xlat_pkg::*;
#(
   parameter int unsigned ORG_W     = 24,
   parameter int unsigned SLOTS     = 7,
   parameter bit          SEL_PURGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ORG_W-1:0] org,
   output tag_t             cur_tag,
   output tag_t             next_tag,
   output logic             purge_en,
   output tag_t             purge_tag,
   output logic             flush_all
);
   localparam int unsigned SIDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   generate
      if (SEL_PURGE) begin : g_stack
         logic [ORG_W-1:0]  org_q [SLOTS];
         logic [SLOTS-1:0]  used_q;
         logic [SLOTS-1:0]  match;
         logic [SIDX_W-1:0] rr_q, hit_idx, free_idx, victim;
         logic              hit, free_found;
         tag_t              cur_q;

         for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
            assign match[s] = used_q[s] && (org_q[s] == org);
         end

         always_comb begin
            hit_idx = '0;
            for (int i = SLOTS - 1; i >= 0; i--)
               if (match[i]) hit_idx = SIDX_W'(i);
         end
         assign hit = |match;

         xlat_first_free #(.N(SLOTS), .IW(SIDX_W)) u_free (
            .busy (used_q),
            .found(free_found),
            .idx  (free_idx)
         );

         assign victim    = free_found ? free_idx : rr_q;
         assign purge_en  = load && !hit;
         assign purge_tag = tag_t'(victim);
         assign flush_all = 1'b0;
         assign cur_tag   = cur_q;
         assign next_tag  = !load ? cur_q : (hit ? tag_t'(hit_idx) : tag_t'(victim));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               used_q <= '0;
               rr_q   <= '0;
               cur_q  <= TAG_NONE;
            end else begin
               cur_q <= next_tag;
               if (purge_en) begin
                  used_q[victim] <= 1'b1;
                  if (!free_found)
                     rr_q <= (rr_q == SIDX_W'(SLOTS - 1)) ? '0 : rr_q + 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (purge_en) org_q[victim] <= org;
         end
      end else begin : g_flush
         tag_t cur_q;
         logic unused_org;
         assign unused_org = ^org;
         assign purge_en   = 1'b0;
         assign purge_tag  = '0;
         assign flush_all  = load;
         assign cur_tag    = cur_q;
         assign next_tag   = load ? tag_t'(0) : cur_q;

         always_ff @(posedge clk) begin
            if (!rst_n) cur_q <= TAG_NONE;
            else        cur_q <= next_tag;
         end
      end
   endgenerate
endmodule

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PFN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tag_t             cur_tag,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   input  logic             flush,
   input  logic             purge_en,
   input  tag_t             purge_tag,
   input  logic             inval_en,
   input  logic [VPN_W-1:0] inval_vpn,
   input  logic             fill_en,
   input  tag_t             fill_tag,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn
);
   localparam int unsigned EIDX_W = $clog2(ENTRIES);

   logic [ENTRIES-1:0] vld_q, keep, hit_vec;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q [ENTRIES];
   tag_t               tag_q [ENTRIES];
   logic [EIDX_W-1:0]  rr_q, free_idx, victim;
   logic               free_found, do_fill;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign keep[e] = vld_q[e] && !flush
                       && !(purge_en && (tag_q[e] == purge_tag))
                       && !(inval_en && (vpn_q[e] == inval_vpn));
      assign hit_vec[e] = vld_q[e] && (vpn_q[e] == lk_vpn)
                          && (tag_q[e] == cur_tag) && (cur_tag != TAG_NONE);
   end

   always_comb begin
      lk_pfn = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (hit_vec[i]) lk_pfn = lk_pfn | pfn_q[i];
   end
   assign lk_hit = |hit_vec;

   xlat_first_free #(.N(ENTRIES), .IW(EIDX_W)) u_free (
      .busy (keep),
      .found(free_found),
      .idx  (free_idx)
   );

   assign victim  = free_found ? free_idx : rr_q;
   assign do_fill = fill_en && (fill_tag != TAG_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         rr_q  <= '0;
      end else begin
         vld_q <= keep | (do_fill ? (ENTRIES'(1) << victim) : '0);
         if (do_fill && !free_found)
            rr_q <= (rr_q == EIDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_fill) begin
         vpn_q[victim] <= fill_vpn;
         pfn_q[victim] <= fill_pfn;
         tag_q[victim] <= fill_tag;
      end
   end
endmodule

// File: rtl/tagged_xlat_buf.sv
module tagged_xlat_buf
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES   = 16,
   parameter int unsigned SLOTS     = 7,
   parameter int unsigned VPN_W     = 20,
   parameter int unsigned PFN_W     = 20,
   parameter int unsigned ORG_W     = 24,
   parameter bit          SEL_PURGE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       org_load,
   input  logic [ORG_W-1:0]           org_val,
   input  logic [VPN_W-1:0]           lk_vpn,
   output logic                       lk_hit,
   output logic [PFN_W-1:0]           lk_pfn,
   input  logic                       fill_en,
   input  logic [VPN_W-1:0]           fill_vpn,
   input  logic [PFN_W-1:0]           fill_pfn,
   input  logic                       purge_all,
   input  logic                       inval_en,
   input  logic [VPN_W-1:0]           inval_vpn,
   output logic [xlat_pkg::TAG_W-1:0] cur_tag
);
   if (SLOTS < 1 || SLOTS > (2 ** TAG_W) - 1) begin : g_bad_slots
      $error("SLOTS must leave one tag code free for the no-space value");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end

   tag_t cur_t, next_t, purge_t;
   logic purge_en, flush_stack;

   xlat_origin_stack #(.ORG_W(ORG_W), .SLOTS(SLOTS), .SEL_PURGE(SEL_PURGE)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (org_load),
      .org      (org_val),
      .cur_tag  (cur_t),
      .next_tag (next_t),
      .purge_en (purge_en),
      .purge_tag(purge_t),
      .flush_all(flush_stack)
   );

   xlat_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_tag  (cur_t),
      .lk_vpn   (lk_vpn),
      .lk_hit   (lk_hit),
      .lk_pfn   (lk_pfn),
      .flush    (purge_all || flush_stack),
      .purge_en (purge_en),
      .purge_tag(purge_t),
      .inval_en (inval_en),
      .inval_vpn(inval_vpn),
      .fill_en  (fill_en),
      .fill_tag (next_t),
      .fill_vpn (fill_vpn),
      .fill_pfn (fill_pfn)
   );

   assign cur_tag = cur_t;
endmodule

// File: rtl/tagged_xlat_buf_chk.sv
module tagged_xlat_buf_chk #(
   parameter int unsigned VPN_W = 20,
   parameter int unsigned PFN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             org_load,
   input logic [VPN_W-1:0] lk_vpn,
   input logic             lk_hit,
   input logic [PFN_W-1:0] lk_pfn,
   input logic             fill_en,
   input logic [VPN_W-1:0] fill_vpn,
   input logic [PFN_W-1:0] fill_pfn,
   input logic             purge_all,
   input logic             inval_en,
   input logic [VPN_W-1:0] inval_vpn,
   input logic [2:0]       cur_tag
);
   a_r9_no_hit_without_space: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_tag == 3'd7) |-> !lk_hit);

   a_r3_tag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !org_load |=> $stable(cur_tag));

   a_r4_load_gives_space: assert property (@(posedge clk) disable iff (!rst_n)
      org_load |=> (cur_tag != 3'd7));

   a_r5_purge_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (purge_all && !fill_en) |=> !lk_hit);

   a_r6_page_gone: assert property (@(posedge clk) disable iff (!rst_n)
      (inval_en && !fill_en) |=> !(lk_hit && (lk_vpn == $past(inval_vpn))));

   a_r7_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !org_load && (cur_tag != 3'd7)) |=>
         ((lk_vpn != $past(fill_vpn)) || (lk_hit && (lk_pfn == $past(fill_pfn)))));

   a_r8_fill_takes_new_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (org_load && fill_en) |=> ((lk_vpn != $past(fill_vpn)) || lk_hit));
endmodule

bind tagged_xlat_buf tagged_xlat_buf_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .org_load (org_load),
   .lk_vpn   (lk_vpn),
   .lk_hit   (lk_hit),
   .lk_pfn   (lk_pfn),
   .fill_en  (fill_en),
   .fill_vpn (fill_vpn),
   .fill_pfn (fill_pfn),
   .purge_all(purge_all),
   .inval_en (inval_en),
   .inval_vpn(inval_vpn),
   .cur_tag  (cur_tag)
);

// File: tb/sim_tagged_xlat_buf.sv
`timescale 1ns/1ps
module sim_tagged_xlat_buf;
   localparam int VW = 20;
   localparam int PW = 20;
   localparam int OW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic org_load = 0, fill_en = 0, purge_all = 0, inval_en = 0;
   logic [OW-1:0] org_val = '0;
   logic [VW-1:0] lk_vpn = '0, fill_vpn = '0, inval_vpn = '0;
   logic [PW-1:0] fill_pfn = '0;
   logic          lk_hit, lk_hit1;
   logic [PW-1:0] lk_pfn, lk_pfn1;
   logic [2:0]    cur_tag, cur_tag1;

   always #4 clk = ~clk;

   tagged_xlat_buf #(.VPN_W(VW), .PFN_W(PW), .ORG_W(OW)) u0 (
      .clk(clk), .rst_n(rst_n), .org_load(org_load), .org_val(org_val),
      .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
      .purge_all(purge_all), .inval_en(inval_en), .inval_vpn(inval_vpn),
      .cur_tag(cur_tag));

   tagged_xlat_buf #(.VPN_W(VW), .PFN_W(PW), .ORG_W(OW), .SEL_PURGE(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .org_load(org_load), .org_val(org_val),
      .lk_vpn(lk_vpn), .lk_hit(lk_hit1), .lk_pfn(lk_pfn1),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
      .purge_all(purge_all), .inval_en(inval_en), .inval_vpn(inval_vpn),
      .cur_tag(cur_tag1));

   int checks = 0, failures = 0;
   bit done = 0;

   // reference model of the selective-purge variant
   logic          m_v   [16];
   logic [VW-1:0] m_vpn [16];
   logic [PW-1:0] m_pfn [16];
   logic [2:0]    m_tag [16];
   logic [OW-1:0] s_org [7];
   logic          s_used[7];
   int            s_rr, f_rr;
   logic [2:0]    m_cur;

   logic          s_hit, s_hit1;
   logic [PW-1:0] s_pfn;
   logic [2:0]    s_tag, s_tag1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] pred_tag(input bit ld, input logic [OW-1:0] o,
                                           output bit miss, output bit had_free);
      int vic;
      miss = 0;
      had_free = 0;
      if (!ld) return m_cur;
      for (int i = 0; i < 7; i++)
         if (s_used[i] && s_org[i] == o) return 3'(i);
      miss = 1;
      vic = -1;
      for (int i = 0; i < 7; i++)
         if (!s_used[i] && vic < 0) vic = i;
      had_free = (vic >= 0);
      if (vic < 0) vic = s_rr;
      return 3'(vic);
   endfunction

   function automatic logic [PW:0] m_look(input logic [VW-1:0] v);
      logic h = 0;
      logic [PW-1:0] p = '0;
      for (int i = 0; i < 16; i++)
         if (m_v[i] && m_vpn[i] == v && m_tag[i] == m_cur && m_cur != 3'd7) begin
            h = 1;
            p = p | m_pfn[i];
         end
      return {h, p};
   endfunction

   task automatic m_update(input bit ld, input logic [OW-1:0] o, input bit fe,
                           input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                           input bit pa, input bit ie, input logic [VW-1:0] iv);
      bit miss, had_free;
      logic [2:0] t;
      logic keep[16];
      int vic;
      t = pred_tag(ld, o, miss, had_free);
      for (int i = 0; i < 16; i++)
         keep[i] = m_v[i] && !pa && !(miss && m_tag[i] == t) && !(ie && m_vpn[i] == iv);
      if (miss) begin
         if (!had_free) s_rr = (s_rr + 1) % 7;
         s_org[t] = o;
         s_used[t] = 1;
      end
      if (fe && t != 3'd7) begin
         vic = -1;
         for (int i = 0; i < 16; i++)
            if (!keep[i] && vic < 0) vic = i;
         if (vic < 0) begin
            vic = f_rr;
            f_rr = (f_rr + 1) % 16;
         end
         keep[vic] = 1;
         m_vpn[vic] = fv;
         m_pfn[vic] = fp;
         m_tag[vic] = t;
      end
      for (int i = 0; i < 16; i++) m_v[i] = keep[i];
      m_cur = t;
   endtask

   // one clock: drive at the falling edge, sample 1 ns later, update the model at the rising edge
   task automatic op(input bit ld, input logic [OW-1:0] o, input bit fe,
                     input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                     input bit pa, input bit ie, input logic [VW-1:0] iv,
                     input logic [VW-1:0] lv, input string req);
      logic [PW:0] e;
      @(negedge clk);
      org_load = ld; org_val = o; fill_en = fe; fill_vpn = fv; fill_pfn = fp;
      purge_all = pa; inval_en = ie; inval_vpn = iv; lk_vpn = lv;
      #1;
      e = m_look(lv);
      s_hit = lk_hit; s_pfn = lk_pfn; s_tag = cur_tag;
      s_hit1 = lk_hit1; s_tag1 = cur_tag1;
      chk({req, " lookup hit"}, 32'(lk_hit), 32'(e[PW]));
      if (e[PW]) chk({req, " lookup frame"}, 32'(lk_pfn), 32'(e[PW-1:0]));
      chk({req, " tag"}, 32'(cur_tag), 32'(m_cur));
      @(posedge clk);
      m_update(ld, o, fe, fv, fp, pa, ie, iv);
   endtask

   task automatic probe(input logic [VW-1:0] v, input string req);
      op(0, '0, 0, '0, '0, 0, 0, '0, v, req);
   endtask
   task automatic ld(input logic [OW-1:0] o, input string req);
      op(1, o, 0, '0, '0, 0, 0, '0, '0, req);
   endtask
   task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input string req);
      op(0, '0, 1, v, p, 0, 0, '0, '0, req);
   endtask

   localparam logic [OW-1:0] OA = 24'h000100, OB = 24'h000200, OC = 24'h000300,
                             OD = 24'h000400, OE = 24'h000500, OF = 24'h000600,
                             OG = 24'h000700, OH = 24'h000800, OI = 24'h000900,
                             OJ = 24'h000A00, OK = 24'h000B00;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit miss, hf;
      logic [2:0] t;
      logic [OW-1:0] o;
      logic [VW-1:0] fv;
      bit l, f;
      void'($urandom(32'd2024));
      for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_tag[i] = '0; end
      for (int i = 0; i < 7; i++) begin s_used[i] = 0; s_org[i] = '0; end
      s_rr = 0; f_rr = 0; m_cur = 3'd7;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset tag", 32'(cur_tag), 32'd7);
      chk("R1 reset hit", 32'(lk_hit), 32'd0);

      // R9: fill before any origin is dropped
      fill(20'd1, 20'h00111, "R9");
      ld(OA, "R4");
      probe(20'd1, "R9");
      chk("R9 dropped fill", 32'(s_hit), 32'd0);
      chk("R4 first free slot", 32'(s_tag), 32'd0);

      // R2 / R7 basic fills and lookups
      fill(20'd1, 20'h000A1, "R7");
      fill(20'd2, 20'h000A2, "R7");
      probe(20'd1, "R2");
      chk("R2 hit", 32'(s_hit), 32'd1);
      chk("R2 frame", 32'(s_pfn), 32'h000A1);
      probe(20'd3, "R2");
      chk("R2 miss absent page", 32'(s_hit), 32'd0);

      // R2 tag mismatch, R3 reuse of held origin
      ld(OB, "R4");
      probe(20'd1, "R2");
      chk("R2 other tag", 32'(s_tag), 32'd1);
      chk("R2 other tag misses", 32'(s_hit), 32'd0);
      fill(20'd1, 20'h000B1, "R7");
      probe(20'd1, "R2");
      chk("R2 frame tag 1", 32'(s_pfn), 32'h000B1);
      ld(OA, "R3");
      probe(20'd1, "R3");
      chk("R3 reuse tag", 32'(s_tag), 32'd0);
      chk("R3 entries kept", 32'(s_pfn), 32'h000A1);

      // R4: fill the stack, then round-robin eviction
      ld(OC, "R4"); ld(OD, "R4"); ld(OE, "R4"); ld(OF, "R4"); ld(OG, "R4");
      probe(20'd1, "R4");
      chk("R4 seventh slot", 32'(s_tag), 32'd6);
      ld(OH, "R4");
      probe(20'd1, "R4");
      chk("R4 evict slot 0", 32'(s_tag), 32'd0);
      chk("R4 evicted entries gone", 32'(s_hit), 32'd0);
      ld(OB, "R4");
      probe(20'd1, "R4");
      chk("R4 other tag kept", 32'(s_hit), 32'd1);
      chk("R4 other tag frame", 32'(s_pfn), 32'h000B1);
      ld(OI, "R4");
      probe(20'd1, "R4");
      chk("R4 round robin slot 1", 32'(s_tag), 32'd1);
      chk("R4 slot 1 purged", 32'(s_hit), 32'd0);

      // R5
      fill(20'd2, 20'h000C2, "R7");
      op(0, '0, 0, '0, '0, 1, 0, '0, 20'd2, "R5");
      probe(20'd2, "R5");
      chk("R5 purge all", 32'(s_hit), 32'd0);
      ld(OH, "R5");
      probe(20'd2, "R5");
      chk("R5 stack kept", 32'(s_tag), 32'd0);

      // R6: page invalidate across two tags
      fill(20'd5, 20'h00055, "R6");
      ld(OI, "R6");
      fill(20'd5, 20'h00065, "R6");
      op(0, '0, 0, '0, '0, 0, 1, 20'd5, 20'd5, "R6");
      probe(20'd5, "R6");
      chk("R6 tag 1 cleared", 32'(s_hit), 32'd0);
      ld(OH, "R6");
      probe(20'd5, "R6");
      chk("R6 tag 0 cleared", 32'(s_hit), 32'd0);

      // R8: load and fill together
      op(1, OJ, 1, 20'd7, 20'h00077, 0, 0, '0, '0, "R8");
      probe(20'd7, "R8");
      chk("R8 new slot", 32'(s_tag), 32'd2);
      chk("R8 fill under new tag", 32'(s_hit), 32'd1);
      chk("R8 frame", 32'(s_pfn), 32'h00077);

      // R7: overflow into round-robin victims
      op(0, '0, 0, '0, '0, 1, 0, '0, '0, "R5");
      for (int i = 0; i < 16; i++) fill(20'(16 + i), 20'(32'h300 + i), "R7");
      fill(20'd40, 20'h00340, "R7");
      probe(20'd16, "R7");
      chk("R7 entry 0 replaced", 32'(s_hit), 32'd0);
      probe(20'd40, "R7");
      chk("R7 new entry", 32'(s_pfn), 32'h00340);
      fill(20'd41, 20'h00341, "R7");
      probe(20'd17, "R7");
      chk("R7 entry 1 replaced", 32'(s_hit), 32'd0);
      probe(20'd18, "R7");
      chk("R7 entry 2 kept", 32'(s_hit), 32'd1);

      // R10: flush-on-load variant (instance u1 shares the inputs)
      ld(OK, "R10");
      fill(20'd50, 20'h00500, "R10");
      probe(20'd50, "R10");
      chk("R10 variant hit", 32'(s_hit1), 32'd1);
      ld(OK, "R10");
      probe(20'd50, "R10");
      chk("R10 variant flushed", 32'(s_hit1), 32'd0);
      chk("R10 variant tag", 32'(s_tag1), 32'd0);

      // random mix, every lookup against the model (R2 R3 R4 R6 R7 R8)
      op(0, '0, 0, '0, '0, 1, 0, '0, '0, "R5");
      for (int n = 0; n < 3000; n++) begin
         l  = ($urandom % 6) == 0;
         o  = 24'(32'h1000 + ($urandom % 10) * 32'h40);
         f  = ($urandom % 3) == 0;
         fv = 20'($urandom % 12);
         t  = pred_tag(l, o, miss, hf);
         op(l, o, f, fv, 20'({t, 12'(fv)}) + 20'h40000,
            ($urandom % 40) == 0, ($urandom % 10) == 0, 20'($urandom % 12),
            20'($urandom % 12), "R2 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule